// File: doc/BRIEF.md
# Bank Group Spacing Guard

This block sits beside a DRAM command scheduler for one channel or sub-channel. It watches the stream of row-open (activate), read, write and precharge commands, each with its bank address. For every command presented, it decides whether enough cycles have passed since the earlier commands that constrain it.

When bank grouping is enabled, two commands that land in the same bank group must be further apart than two commands in different groups. With grouping disabled, the short spacing applies everywhere. The read-to-precharge spacing is tracked per bank. Its limit is chosen by the grouping setting, not by the group relationship.

The scheduler uses the four ready flags to pick a legal command for the bank it is presenting. A command presented while its flag is low raises the violation flag in the same cycle and is dropped from the history. The bank count (8, 16 or 32) and every spacing limit are parameters. Each limit must be at least 1, and each long limit must be no smaller than its short one.

Top module: `bgrp_spacing_guard`

## Requirements
- R1: After reset no command has any history: all four ready flags are high and `viol` is low whenever no command is presented.
- R2: With 8 banks the group of a bank is its index divided by 2 (four groups). With 16 banks it is the index divided by 4 (four groups).
- R3: With 32 banks, bank index bit 4 is the stack bit and forms the top bank bit. The group is the index divided by 4, giving eight groups, so banks 0 and 16 are in different groups.
- R4: An activate is ready only when at least T_RRD_S cycles have passed since any accepted activate. When grouping is enabled, it also needs T_RRD_L cycles since the last accepted activate in its own group.
- R5: A read needs T_CCD_S cycles since any accepted read. With grouping enabled it also needs T_CCD_L cycles since the last accepted read in its group.
- R6: A write needs T_CCD_S cycles since any accepted write. With grouping enabled it also needs T_CCD_L cycles since the last accepted write in its group.
- R7: A read needs T_WTR_S cycles since any accepted write. With grouping enabled it also needs T_WTR_L cycles since the last accepted write in its group.
- R8: A precharge is constrained only by the last accepted read to the same bank. It needs T_RTP_L cycles when grouping is enabled and T_RTP_S cycles when it is disabled.
- R9: Command encoding on `cmd_type` is 0 activate, 1 read, 2 write, 3 precharge. `viol` is high in the same cycle exactly when `cmd_valid` is high and the ready flag for that type is low. Such a command is not recorded.
- R10: A command accepted in cycle t and a later command presented in cycle t+k are spaced by k cycles. The ready flags are combinational on the presented bank and `grp_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_en | input | 1 | Bank grouping enable |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_type | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| rdy_act | output | 1 | An activate to cmd_bank is legal now |
| rdy_rd | output | 1 | A read to cmd_bank is legal now |
| rdy_wr | output | 1 | A write to cmd_bank is legal now |
| rdy_pre | output | 1 | A precharge to cmd_bank is legal now |
| viol | output | 1 | Presented command breaks a spacing rule |

## Verification
The bench builds three copies side by side, with 8, 16 and 32 banks, and drives them with one shared command stream. A single bank index therefore falls into the same group on one copy and into different groups on another. This exposes both bank-to-group maps and the stack bit of the 32-bank case. All short and long limits are set to distinct small values, so every same-group versus cross-group boundary, and the switch between the two precharge limits, lies within a few cycles of random traffic.

// File: rtl/bgrp_spacing_guard.sv
module bgrp_spacing_guard #(
  parameter int NUM_BANKS = 16,
  parameter int T_RRD_S = 2,
  parameter int T_RRD_L = 4,
  parameter int T_CCD_S = 2,
  parameter int T_CCD_L = 3,
  parameter int T_WTR_S = 3,
  parameter int T_WTR_L = 5,
  parameter int T_RTP_S = 2,
  parameter int T_RTP_L = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         grp_en,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_type,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic                         rdy_act,
  output logic                         rdy_rd,
  output logic                         rdy_wr,
  output logic                         rdy_pre,
  output logic                         viol
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int NUM_GRPS = (NUM_BANKS == 32) ? 8 : 4;
  localparam int GRP_SHIFT = (NUM_BANKS == 8) ? 1 : 2;
  localparam int GRP_W = $clog2(NUM_GRPS);
  localparam int MAX_A = T_RRD_S; localparam int MAX_B = (T_RRD_L > MAX_A) ? T_RRD_L : MAX_A;
  localparam int MAX_C = (T_CCD_S > MAX_B) ? T_CCD_S : MAX_B;
  localparam int MAX_D = (T_CCD_L > MAX_C) ? T_CCD_L : MAX_C;
  localparam int MAX_E = (T_WTR_S > MAX_D) ? T_WTR_S : MAX_D;
  localparam int MAX_F = (T_WTR_L > MAX_E) ? T_WTR_L : MAX_E;
  localparam int MAX_G = (T_RTP_S > MAX_F) ? T_RTP_S : MAX_F;
  localparam int MAX_T = (T_RTP_L > MAX_G) ? T_RTP_L : MAX_G;
  localparam int AGE_W = $clog2(MAX_T + 1);
  localparam logic [AGE_W-1:0] SAT = AGE_W'(MAX_T);
  localparam logic [AGE_W-1:0] ONE = AGE_W'(1);

  localparam logic [1:0] OP_ACT = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_PRE = 2'd3;

  // Saturating ages: cycles since the last accepted command of a kind.
  logic [AGE_W-1:0] any_act, any_rd, any_wr;
  logic [AGE_W-1:0] grp_act [NUM_GRPS];
  logic [AGE_W-1:0] grp_rd  [NUM_GRPS];
  logic [AGE_W-1:0] grp_wr  [NUM_GRPS];
  logic [AGE_W-1:0] bank_rd [NUM_BANKS];

  function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
    return (a >= SAT) ? SAT : a + ONE;
  endfunction

  wire [GRP_W-1:0] grp = GRP_W'(cmd_bank >> GRP_SHIFT);

  assign rdy_act = (any_act >= AGE_W'(T_RRD_S)) &&
                   (!grp_en || grp_act[grp] >= AGE_W'(T_RRD_L));
  assign rdy_rd  = (any_rd >= AGE_W'(T_CCD_S)) && (any_wr >= AGE_W'(T_WTR_S)) &&
                   (!grp_en || (grp_rd[grp] >= AGE_W'(T_CCD_L) &&
                                grp_wr[grp] >= AGE_W'(T_WTR_L)));
  assign rdy_wr  = (any_wr >= AGE_W'(T_CCD_S)) &&
                   (!grp_en || grp_wr[grp] >= AGE_W'(T_CCD_L));
  assign rdy_pre = bank_rd[cmd_bank] >= (grp_en ? AGE_W'(T_RTP_L) : AGE_W'(T_RTP_S));

  logic sel_ok;
  always_comb begin
    case (cmd_type)
      OP_ACT:  sel_ok = rdy_act;
      OP_RD:   sel_ok = rdy_rd;
      OP_WR:   sel_ok = rdy_wr;
      default: sel_ok = rdy_pre;
    endcase
  end

  wire acc = cmd_valid && sel_ok;
  assign viol = cmd_valid && !sel_ok;

  wire acc_act = acc && cmd_type == OP_ACT;
  wire acc_rd  = acc && cmd_type == OP_RD;
  wire acc_wr  = acc && cmd_type == OP_WR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_act <= SAT; any_rd <= SAT; any_wr <= SAT;
      for (int i = 0; i < NUM_GRPS; i++) begin
        grp_act[i] <= SAT; grp_rd[i] <= SAT; grp_wr[i] <= SAT;
      end
      for (int i = 0; i < NUM_BANKS; i++) bank_rd[i] <= SAT;
    end else begin
      any_act <= acc_act ? ONE : bump(any_act);
      any_rd  <= acc_rd  ? ONE : bump(any_rd);
      any_wr  <= acc_wr  ? ONE : bump(any_wr);
      for (int i = 0; i < NUM_GRPS; i++) begin
        grp_act[i] <= (acc_act && grp == GRP_W'(i)) ? ONE : bump(grp_act[i]);
        grp_rd[i]  <= (acc_rd  && grp == GRP_W'(i)) ? ONE : bump(grp_rd[i]);
        grp_wr[i]  <= (acc_wr  && grp == GRP_W'(i)) ? ONE : bump(grp_wr[i]);
      end
      for (int i = 0; i < NUM_BANKS; i++)
        bank_rd[i] <= (acc_rd && cmd_bank == BANK_W'(i)) ? ONE : bump(bank_rd[i]);
    end
  end

  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rdy_act && rdy_rd && rdy_wr && rdy_pre));

  a_r4_act_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_RRD_S > 1) && acc_act) |=> !rdy_act);

  a_r7_wr_blocks_rd: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_WTR_S > 1) && acc_wr) |=> !rdy_rd);

  a_r8_rd_blocks_pre_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_RTP_S > 1) && (T_RTP_L > 1) && acc_rd) |=>
      ((cmd_bank != $past(cmd_bank)) || !rdy_pre));

  a_r9_rejected_act_not_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && cmd_type == OP_ACT) |=> (any_act != ONE));
endmodule

// File: tb/bgrp_spacing_guard_tb.sv
`timescale 1ns/1ps
module bgrp_spacing_guard_tb_top;
  localparam int RRD_S = 2, RRD_L = 4, CCD_S = 2, CCD_L = 3;
  localparam int WTR_S = 3, WTR_L = 5, RTP_S = 2, RTP_L = 4;

  logic clk = 0, rst_n = 0, grp_en = 0, cmd_valid = 0;
  logic [1:0] cmd_type = 0;
  logic [4:0] bank_in = 0;
  logic ra [3], rr [3], rw [3], rp [3], vi [3];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bgrp_spacing_guard #(.NUM_BANKS(8), .T_RRD_S(RRD_S), .T_RRD_L(RRD_L), .T_CCD_S(CCD_S),
    .T_CCD_L(CCD_L), .T_WTR_S(WTR_S), .T_WTR_L(WTR_L), .T_RTP_S(RTP_S), .T_RTP_L(RTP_L))
  dut_i (.clk(clk), .rst_n(rst_n), .grp_en(grp_en), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(bank_in[2:0]), .rdy_act(ra[0]), .rdy_rd(rr[0]), .rdy_wr(rw[0]), .rdy_pre(rp[0]), .viol(vi[0]));
  bgrp_spacing_guard #(.NUM_BANKS(16), .T_RRD_S(RRD_S), .T_RRD_L(RRD_L), .T_CCD_S(CCD_S),
    .T_CCD_L(CCD_L), .T_WTR_S(WTR_S), .T_WTR_L(WTR_L), .T_RTP_S(RTP_S), .T_RTP_L(RTP_L))
  dut16_i (.clk(clk), .rst_n(rst_n), .grp_en(grp_en), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(bank_in[3:0]), .rdy_act(ra[1]), .rdy_rd(rr[1]), .rdy_wr(rw[1]), .rdy_pre(rp[1]), .viol(vi[1]));
  bgrp_spacing_guard #(.NUM_BANKS(32), .T_RRD_S(RRD_S), .T_RRD_L(RRD_L), .T_CCD_S(CCD_S),
    .T_CCD_L(CCD_L), .T_WTR_S(WTR_S), .T_WTR_L(WTR_L), .T_RTP_S(RTP_S), .T_RTP_L(RTP_L))
  dut32_i (.clk(clk), .rst_n(rst_n), .grp_en(grp_en), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(bank_in), .rdy_act(ra[2]), .rdy_rd(rr[2]), .rdy_wr(rw[2]), .rdy_pre(rp[2]), .viol(vi[2]));

  // Reference history: index 0 activate, 1 read, 2 write.
  int last_any [3][3];
  int last_grp [3][3][8];
  int last_brd [3][32];

  function automatic int grp_of(int k, int b);
    return (k == 0) ? b / 2 : b / 4;   // R2, R3
  endfunction

  task automatic clear_model();
    for (int k = 0; k < 3; k++) begin
      for (int t = 0; t < 3; t++) begin
        last_any[k][t] = -1000;
        for (int g = 0; g < 8; g++) last_grp[k][t][g] = -1000;
      end
      for (int b = 0; b < 32; b++) last_brd[k][b] = -1000;
    end
  endtask

  task automatic chk(bit act, bit exp, string tag, string what, int k);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s dut%0d banks=%0d cyc=%0d: got %0b expected %0b",
               tag, what, k, 8 << k, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input int t, input int b, input bit en, input string tag);
    @(negedge clk);
    cmd_valid = v; cmd_type = 2'(t); bank_in = 5'(b); grp_en = en;
    #1;
    for (int k = 0; k < 3; k++) begin
      int mb, g, now;
      bit e_act, e_rd, e_wr, e_pre, e_sel;
      mb = b % (8 << k); g = grp_of(k, mb); now = cyc;
      e_act = (now - last_any[k][0] >= RRD_S) && (!en || now - last_grp[k][0][g] >= RRD_L);
      e_rd  = (now - last_any[k][1] >= CCD_S) && (now - last_any[k][2] >= WTR_S) &&
              (!en || (now - last_grp[k][1][g] >= CCD_L && now - last_grp[k][2][g] >= WTR_L));
      e_wr  = (now - last_any[k][2] >= CCD_S) && (!en || now - last_grp[k][2][g] >= CCD_L);
      e_pre = now - last_brd[k][mb] >= (en ? RTP_L : RTP_S);
      e_sel = (t == 0) ? e_act : (t == 1) ? e_rd : (t == 2) ? e_wr : e_pre;
      chk(ra[k], e_act, {tag, " R4"}, "rdy_act", k);
      chk(rr[k], e_rd,  {tag, " R5 R7"}, "rdy_rd", k);
      chk(rw[k], e_wr,  {tag, " R6"}, "rdy_wr", k);
      chk(rp[k], e_pre, {tag, " R8"}, "rdy_pre", k);
      chk(vi[k], v && !e_sel, {tag, " R9"}, "viol", k);
      if (v && e_sel && t < 3) begin
        last_any[k][t] = now;
        last_grp[k][t][g] = now;
        if (t == 1) last_brd[k][mb] = now;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0b61));
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: clean state after reset
    step(0, 0, 0, 1, "R1 reset");
    step(0, 1, 7, 0, "R1 reset");
    // R2/R3 group maps and activate spacing (R4, R10)
    step(1, 0, 0, 1, "R4 act");
    step(1, 0, 1, 1, "R4 too close");
    step(1, 0, 2, 1, "R2 map");
    step(0, 0, 0, 1, "R4 idle");
    step(0, 0, 0, 1, "R4 idle");
    step(1, 0, 16, 1, "R3 stack bit");
    step(0, 0, 16, 1, "R3 idle");
    step(1, 0, 16, 0, "R4 grouping off");
    // R5/R6/R7 column spacing
    step(1, 2, 5, 1, "R6 wr");
    step(1, 1, 5, 1, "R7 wr->rd");
    step(1, 2, 5, 1, "R6 wr->wr");
    step(1, 2, 9, 1, "R6 cross group");
    step(0, 1, 5, 1, "R7 wait");
    step(1, 1, 5, 1, "R7 same group");
    step(1, 1, 13, 0, "R5 grouping off");
    // R8 read to precharge per bank
    step(1, 1, 3, 1, "R8 rd");
    step(1, 3, 3, 1, "R8 same bank");
    step(1, 3, 4, 1, "R8 other bank");
    step(1, 3, 3, 0, "R8 short limit");
    step(1, 3, 3, 1, "R8 long limit");
    // Random traffic
    begin
      bit en = 1;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 60) == 0) en = ~en;
        step(($urandom % 10) < 6, $urandom % 4, $urandom % 32, en, "R10 random");
      end
    end
    step(0, 0, 0, 1, "R9 idle");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule